// File: doc/BRIEF.md
# Walsh-Code CDMA Bus Transceiver

This block lets up to six nodes share one signed bus by code division. Each node that transmits spreads one data bit over a window of eight chip periods using an orthogonal Walsh code selected by a 3-bit key. The bus carries the arithmetic sum of every active chip stream, not a wired OR. Each enabled receiver correlates the eight summed chips of a window against its own key. A result of +8 yields a 1, a result of -8 yields a 0, and a result of 0 means nobody used that key. Any other value is reported as a protocol error.

One shared chip counter sets the phase of every window, so all spreaders and correlators line up. Keys, enables and data bits for both directions are captured once per window, at the last chip of the window before. A node therefore changes its configuration only between windows. The key allocation itself comes from outside the block.

Top module: `cdma_bus_xcvr`

## Requirements
- R1: After reset `chip_idx_o` is 0. It then counts 0,1,...,7 and wraps to 0, one step per clock.
- R2: The chip at position j of the code with key k is +1 when the bitwise AND of k and j has an even number of ones, and -1 otherwise. So key 0 is all +1, key 6 is +,+,-,-,-,-,+,+, key 4 is +,+,+,+,-,-,-,-, and key 2 is +,+,-,-,+,+,-,-.
- R3: During chip j of a window, `bus_sum_o` is the signed sum of the chips of all enabled transmitters. A data bit of 1 sends the code and a data bit of 0 sends the negated code. As an example, keys 0, 6 and 4 all sending 1 give +3,+3,+1,+1,-1,-1,+1,+1.
- R4: Each transmitter samples its enable, bit and key at the clock edge that ends chip 7. These values hold for the whole next window, and any change to the inputs within the window has no effect on the bus or on the decoded bits.
- R5: For an enabled receiver whose correlation is +8 or -8, `rx_valid_o` is high for exactly one cycle, the one in which `chip_idx_o` is 0 right after the window. In that cycle `rx_bit_o` is 1 for +8 and 0 for -8. `rx_bit_o` is 0 whenever `rx_valid_o` is low.
- R6: An enabled receiver whose key no transmitter used (correlation 0) raises neither `rx_valid_o` nor `rx_err_o`.
- R7: An enabled receiver whose correlation is anything other than 0, +8 or -8 raises `rx_err_o` for that same one cycle, and not `rx_valid_o`.
- R8: A receiver that was disabled for a window raises none of its outputs for that window.
- R9: During reset and right after it, the bus is 0 and all receiver outputs are low.
- R10: With all six nodes sending at once on six distinct keys, every receiver that holds one of those keys recovers its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 6 | Per-node transmit enable for the next window |
| tx_bit_i | input | 6 | Per-node data bit for the next window |
| tx_key_i | input | 18 | Per-node 3-bit transmit key, node n at bits [3n+2:3n] |
| rx_en_i | input | 6 | Per-node receive enable for the next window |
| rx_key_i | input | 18 | Per-node 3-bit receive key, node n at bits [3n+2:3n] |
| chip_idx_o | output | 3 | Current chip position in the window |
| bus_sum_o | output | 4 | Signed chip sum on the shared bus |
| rx_valid_o | output | 6 | Per-node decoded bit valid pulse |
| rx_bit_o | output | 6 | Per-node decoded bit |
| rx_err_o | output | 6 | Per-node correlation error pulse |

## Verification
With correctly allocated keys, orthogonality means the error path can never be reached, so the stimulus has to break the allocation on purpose. The bench gives two transmitters the same key and the same bit, which drives a receiver on that key to a correlation of +16. A second hard case is a change to a transmit input in the middle of a window. That stimulus is applied at chip 3, and the bus values and the decoded bit are compared with those from the values captured at the window start.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    parameter int NODES    = 6;
    parameter int CHIP_LOG = 3;
    parameter int BUS_W    = 4;

    localparam int CHIPS = 1 << CHIP_LOG;
    localparam int ACC_W = BUS_W + CHIP_LOG;

    typedef logic        [CHIP_LOG-1:0] key_t;
    typedef logic signed [BUS_W-1:0]    bus_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
    typedef logic signed [1:0]          chip_t;

    // Hadamard row k, column j: negative when k&j has odd weight
    function automatic logic chip_is_neg(key_t key, key_t pos);
        return ^(key & pos);
    endfunction
endpackage

// File: rtl/cdma_chip_timer.sv
module cdma_chip_timer
    import cdma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    output key_t idx_o,
    output logic last_o
);
    typedef struct packed {
        key_t idx;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.idx = s_q.idx + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign idx_o  = s_q.idx;
    assign last_o = (s_q.idx == key_t'(CHIPS - 1));
endmodule

// File: rtl/cdma_spreader.sv
module cdma_spreader
    import cdma_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  last_i,
    input  key_t  idx_i,
    input  logic  en_i,
    input  logic  bit_i,
    input  key_t  key_i,
    output chip_t chip_o
);
    typedef struct packed {
        logic en;
        logic dbit;
        key_t key;
    } spr_s;

    spr_s s_d, s_q;
    logic neg;

    always_comb begin
        s_d = s_q;
        if (last_i) begin
            s_d.en   = en_i;
            s_d.dbit = bit_i;
            s_d.key  = key_i;
        end
        neg = chip_is_neg(s_q.key, idx_i) ^ ~s_q.dbit;
        if (!s_q.en)  chip_o = '0;
        else if (neg) chip_o = chip_t'(-1);
        else          chip_o = chip_t'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end
endmodule

// File: rtl/cdma_correlator.sv
module cdma_correlator
    import cdma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic last_i,
    input  key_t idx_i,
    input  bus_t bus_i,
    input  logic en_i,
    input  key_t key_i,
    output logic valid_o,
    output logic bit_o,
    output logic err_o
);
    localparam acc_t FULL = acc_t'(CHIPS);

    typedef struct packed {
        logic en;
        key_t key;
        acc_t acc;
        logic valid;
        logic dbit;
        logic err;
    } cor_s;

    cor_s s_d, s_q;
    acc_t term;
    acc_t total;

    always_comb begin
        term  = chip_is_neg(s_q.key, idx_i) ? -acc_t'(bus_i) : acc_t'(bus_i);
        total = s_q.acc + term;
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.dbit  = 1'b0;
        s_d.err   = 1'b0;
        if (last_i) begin
            s_d.acc = '0;
            s_d.en  = en_i;
            s_d.key = key_i;
            if (s_q.en) begin
                if (total == FULL) begin
                    s_d.valid = 1'b1;
                    s_d.dbit  = 1'b1;
                end else if (total == -FULL) begin
                    s_d.valid = 1'b1;
                end else if (total != '0) begin
                    s_d.err = 1'b1;
                end
            end
        end else begin
            s_d.acc = total;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign valid_o = s_q.valid;
    assign bit_o   = s_q.dbit;
    assign err_o   = s_q.err;
endmodule

// File: rtl/cdma_bus_xcvr.sv
module cdma_bus_xcvr
    import cdma_pkg::*;
(
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [NODES-1:0]          tx_en_i,
    input  logic [NODES-1:0]          tx_bit_i,
    input  logic [NODES*CHIP_LOG-1:0] tx_key_i,
    input  logic [NODES-1:0]          rx_en_i,
    input  logic [NODES*CHIP_LOG-1:0] rx_key_i,
    output key_t                      chip_idx_o,
    output bus_t                      bus_sum_o,
    output logic [NODES-1:0]          rx_valid_o,
    output logic [NODES-1:0]          rx_bit_o,
    output logic [NODES-1:0]          rx_err_o
);
    logic  last;
    key_t  idx;
    chip_t chips [NODES];
    bus_t  sum;

    cdma_chip_timer u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .idx_o  (idx),
        .last_o (last)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        cdma_spreader u_spr (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .last_i (last),
            .idx_i  (idx),
            .en_i   (tx_en_i[n]),
            .bit_i  (tx_bit_i[n]),
            .key_i  (tx_key_i[n*CHIP_LOG +: CHIP_LOG]),
            .chip_o (chips[n])
        );

        cdma_correlator u_cor (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .last_i  (last),
            .idx_i   (idx),
            .bus_i   (sum),
            .en_i    (rx_en_i[n]),
            .key_i   (rx_key_i[n*CHIP_LOG +: CHIP_LOG]),
            .valid_o (rx_valid_o[n]),
            .bit_o   (rx_bit_o[n]),
            .err_o   (rx_err_o[n])
        );
    end

    always_comb begin
        sum = '0;
        for (int n = 0; n < NODES; n++) begin
            sum = sum + bus_t'(chips[n]);
        end
    end

    assign chip_idx_o = idx;
    assign bus_sum_o  = sum;
endmodule

// File: rtl/cdma_bus_xcvr_chk.sv
module cdma_bus_xcvr_chk
    import cdma_pkg::*;
(
    input logic                      clk_i,
    input logic                      rst_ni,
    input key_t                      chip_idx_o,
    input bus_t                      bus_sum_o,
    input logic [NODES-1:0]          rx_valid_o,
    input logic [NODES-1:0]          rx_bit_o,
    input logic [NODES-1:0]          rx_err_o
);
    localparam key_t LAST = key_t'(CHIPS - 1);

    AST_CHIP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chip_idx_o == LAST) |=> (chip_idx_o == '0)); // R1

    AST_CHIP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (chip_idx_o != LAST) |=> (chip_idx_o == key_t'($past(chip_idx_o) + 1'b1))); // R1

    AST_BUS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sum_o <= NODES) && (bus_sum_o >= -NODES)); // R3

    AST_RESULT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|rx_valid_o) || (|rx_err_o)) |-> (chip_idx_o == '0)); // R5

    AST_BIT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_bit_o & ~rx_valid_o) == '0); // R5

    AST_VALID_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_valid_o & rx_err_o) == '0); // R7

    AST_PULSE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(rx_valid_o | rx_err_o)) |=> ((rx_valid_o | rx_err_o) == '0)); // R5
endmodule

bind cdma_bus_xcvr cdma_bus_xcvr_chk chk_i (.*);

// File: tb/cdma_bus_xcvr_tb_top.sv
module cdma_bus_xcvr_tb_top;
    import cdma_pkg::*;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic [NODES-1:0] tx_en_i = '0;
    logic [NODES-1:0] tx_bit_i = '0;
    logic [NODES-1:0][CHIP_LOG-1:0] tx_key_i = '0;
    logic [NODES-1:0] rx_en_i = '0;
    logic [NODES-1:0][CHIP_LOG-1:0] rx_key_i = '0;
    key_t chip_idx_o;
    bus_t bus_sum_o;
    logic [NODES-1:0] rx_valid_o, rx_bit_o, rx_err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    cdma_bus_xcvr dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .tx_en_i(tx_en_i), .tx_bit_i(tx_bit_i), .tx_key_i(tx_key_i),
        .rx_en_i(rx_en_i), .rx_key_i(rx_key_i),
        .chip_idx_o(chip_idx_o), .bus_sum_o(bus_sum_o),
        .rx_valid_o(rx_valid_o), .rx_bit_o(rx_bit_o), .rx_err_o(rx_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // code chip as a product over key bits of (-1 when both key bit and position bit set)
    function automatic int wchip(int k, int j);
        int s = 1;
        for (int b = 0; b < CHIP_LOG; b++) begin
            if (((k >> b) & 1) == 1 && ((j >> b) & 1) == 1) s = -s;
        end
        return s;
    endfunction

    task automatic wait_last();
        @(negedge clk_i);
        while (chip_idx_o != key_t'(CHIPS - 1)) @(negedge clk_i);
    endtask

    task automatic run_window(
        input logic [NODES-1:0] ten, input logic [NODES-1:0] tbit,
        input logic [NODES-1:0][CHIP_LOG-1:0] tk,
        input logic [NODES-1:0] ren, input logic [NODES-1:0][CHIP_LOG-1:0] rk,
        input bit flip_mid, input string req);
        int expbus [CHIPS];
        int corr, ev, eb, ee;
        string rq;
        wait_last();
        tx_en_i = ten; tx_bit_i = tbit; tx_key_i = tk;
        rx_en_i = ren; rx_key_i = rk;
        for (int j = 0; j < CHIPS; j++) begin
            expbus[j] = 0;
            for (int n = 0; n < NODES; n++) begin
                if (ten[n]) expbus[j] += (tbit[n] ? 1 : -1) * wchip(int'(tk[n]), j);
            end
        end
        for (int j = 0; j < CHIPS; j++) begin
            @(negedge clk_i);
            chk(int'(chip_idx_o) == j, "R1", "chip index", int'(chip_idx_o), j);
            chk(int'(bus_sum_o) == expbus[j], req, "bus sum", int'(bus_sum_o), expbus[j]);
            if (flip_mid && j == 3) tx_bit_i = ~tbit;
            if (j == CHIPS - 1) begin
                tx_en_i = '0; tx_bit_i = '0; rx_en_i = '0;
            end
        end
        @(negedge clk_i);
        for (int n = 0; n < NODES; n++) begin
            corr = 0;
            for (int j = 0; j < CHIPS; j++) corr += expbus[j] * wchip(int'(rk[n]), j);
            ev = (ren[n] && (corr == CHIPS || corr == -CHIPS)) ? 1 : 0;
            eb = (ev == 1 && corr > 0) ? 1 : 0;
            ee = (ren[n] && corr != 0 && ev == 0) ? 1 : 0;
            if (!ren[n])      rq = "R8";
            else if (ee == 1) rq = "R7";
            else if (ev == 1) rq = flip_mid ? "R4" : "R5";
            else              rq = "R6";
            chk(int'(rx_valid_o[n]) == ev, rq, $sformatf("valid node %0d", n), int'(rx_valid_o[n]), ev);
            chk(int'(rx_bit_o[n]) == eb, rq, $sformatf("bit node %0d", n), int'(rx_bit_o[n]), eb);
            chk(int'(rx_err_o[n]) == ee, rq, $sformatf("err node %0d", n), int'(rx_err_o[n]), ee);
        end
    endtask

    task automatic t_reset(); // R9
        chk(chip_idx_o == '0, "R9", "chip index in reset", int'(chip_idx_o), 0);
        chk(bus_sum_o == '0, "R9", "bus in reset", int'(bus_sum_o), 0);
        chk(rx_valid_o == '0 && rx_err_o == '0, "R9", "rx outputs in reset",
            int'(rx_valid_o | rx_err_o), 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(int'(chip_idx_o) == 1, "R1", "chip index after first edge", int'(chip_idx_o), 1);
        chk(bus_sum_o == '0, "R9", "bus after reset", int'(bus_sum_o), 0);
        chk(rx_valid_o == '0 && rx_err_o == '0, "R9", "rx after reset",
            int'(rx_valid_o | rx_err_o), 0);
    endtask

    task automatic t_codes(); // R2: each key alone, bit 1
        for (int k = 0; k < CHIPS; k++) begin
            logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
            tk[0] = key_t'(k);
            run_window(6'b000001, 6'b000001, tk, 6'b000010, tk, 1'b0, "R2");
        end
    endtask

    task automatic t_example(); // R3: keys 0,6,4 all ones; receiver on unused key 2 (R6)
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        tk[0] = 3'd0; tk[2] = 3'd6; tk[4] = 3'd4;
        rk[1] = 3'd0; rk[3] = 3'd6; rk[5] = 3'd4; rk[0] = 3'd2;
        run_window(6'b010101, 6'b010101, tk, 6'b101011, rk, 1'b0, "R3");
    endtask

    task automatic t_mixed(); // R5: zeros and ones mixed
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        tk[0] = 3'd1; tk[2] = 3'd5; tk[4] = 3'd7;
        rk[1] = 3'd1; rk[3] = 3'd5; rk[5] = 3'd7;
        run_window(6'b010101, 6'b000100, tk, 6'b101010, rk, 1'b0, "R3");
    endtask

    task automatic t_all_six(); // R10
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        for (int n = 0; n < NODES; n++) begin
            tk[n] = key_t'(n + 1);
            rk[n] = key_t'(((n + 3) % NODES) + 1);
        end
        run_window(6'b111111, 6'b101100, tk, 6'b111111, rk, 1'b0, "R10");
    endtask

    task automatic t_collision(); // R7: two nodes on key 3, same bit -> correlation 16
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        tk[0] = 3'd3; tk[1] = 3'd3; tk[2] = 3'd5;
        rk[3] = 3'd3; rk[4] = 3'd5;
        run_window(6'b000111, 6'b000011, tk, 6'b011000, rk, 1'b0, "R7");
    endtask

    task automatic t_mid_change(); // R4
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        tk[1] = 3'd6; tk[3] = 3'd2;
        rk[0] = 3'd6; rk[2] = 3'd2;
        run_window(6'b001010, 6'b000010, tk, 6'b000101, rk, 1'b1, "R4");
    endtask

    task automatic t_rx_off(); // R8
        logic [NODES-1:0][CHIP_LOG-1:0] tk = '0;
        logic [NODES-1:0][CHIP_LOG-1:0] rk = '0;
        tk[0] = 3'd4; tk[1] = 3'd3; tk[2] = 3'd3;
        rk[0] = 3'd4; rk[1] = 3'd3; rk[5] = 3'd4;
        run_window(6'b000111, 6'b000111, tk, 6'b000000, rk, 1'b0, "R8");
    endtask

    initial begin
        t_reset();
        t_codes();
        t_example();
        t_mixed();
        t_all_six();
        t_collision();
        t_mid_change();
        t_rx_off();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule